// File: doc/BRIEF.md
# Task Descriptor Switch Sequencer

This block is a multi-cycle controller inside a processor core. It carries out four hardware task operations against a table of task descriptors in memory: calling another process, returning from such a call, switching to another process, and switching while leaving an exception or interrupt handler. A command arrives with a target descriptor index, the identifier the issuer expects that descriptor to carry, and an optional segment argument. The block checks who issued the request and whether the target descriptor is acceptable. It then moves context between the core's register context and descriptor words in memory, over a single-port word memory and a single-port context access port.

Each descriptor occupies `NREG+5` consecutive words starting at `BASE + index*(NREG+5)`. Word 0 holds the identifier in its upper half. The flag field sits directly below the identifier: the valid bit is at position `XLEN/2-FLAG_W` and the running bit is one above it. Word 2 holds the PR value used when the task is called. Word 3 holds the callable segment index in its upper half and the current process field in its lower half. Word 4 holds the segment descriptor word. Words 5 and up hold the saved register array, where element 0 is the IP and element 1 is the stack pointer. Context slots on the register port are numbered as follows: 0..NREG-1 are the register array, NREG is the segment word, NREG+1 is PR, and NREG+2 is the passed segment.

A refusal is reported with a one-cycle `exc` pulse and a cause code. Cause 1 is a privilege violation, 2 a second switch in one instruction queue, 3 an identifier mismatch, 4 an invalid target and 5 a target that is already running. Success is reported with a one-cycle `done` pulse.

Top module: `tss_switch_seq`

## Requirements
- R1: Descriptor word w of entry i is accessed at address BASE + i*(NREG+5) + w. At most one memory access happens per cycle, and read data returns in the cycle after the read.
- R2: A call or switch whose issuer differs from the original process, a return whose issuer equals the original process, and a handler-exit switch while no handler is active are all refused with cause 1, with no memory access.
- R3: For call and switch, a target whose identifier differs from the supplied one is refused with cause 3. For call, switch and handler-exit, a target without the valid flag is refused with cause 4. For switch and handler-exit, a target with the running flag set is refused with cause 5. A refused command leaves every descriptor word unchanged.
- R4: A call stores the caller's IP (slot 0), stack pointer (slot 1), segment word and PR into the current entry's words 5, 6, 4 and 2.
- R5: A call writes the target index into the low half of the current entry's word 3 and keeps its upper half. It loads the callee's word 4 into the segment slot and its word 2 into the PR slot. It sets the IP slot to the callee's callable segment index in the upper half with a zero offset, and leaves other register slots untouched.
- R6: A call whose segment argument is all ones leaves the passed-segment slot unchanged. Any other argument is written into that slot.
- R7: A return reloads IP, stack pointer, segment word and PR from the current entry's words 5, 6, 4 and 2. It writes the original process identifier into the low half of word 3 and leaves general registers untouched.
- R8: A switch saves every register slot, the segment word and PR into the current entry. It loads all of them from the target entry, clears the running flag of the current entry and sets it in the target entry.
- R9: A handler-exit switch saves the supplied handler-return IP and PR in place of the live IP and PR. It pulses `irq_reenable` together with `done`.
- R10: A handler-exit switch from a current entry without the valid flag performs no save and no flag write to that entry, but still loads the target.
- R11: A second command accepted without an intervening `queue_new` is refused with cause 2. A `queue_new` in the same cycle as the command counts as a fresh queue.
- R12: After acceptance, no memory or context write occurs until `queue_drained` is seen high.
- R13: `busy` is high from the cycle after acceptance until the end of the sequence. Exactly one of `done` or `exc` pulses for one cycle to end each command. Commands presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 call, 1 return, 2 switch, 3 handler-exit switch |
| cmd_idx | input | IDX_W | Target descriptor index |
| cmd_id | input | XLEN/2 | Expected target identifier |
| cmd_seg | input | XLEN/2 | Segment argument, all ones means none |
| cur_idx | input | IDX_W | Descriptor index of the running task |
| issuer_pid | input | XLEN/2 | Process issuing the command |
| orig_pid | input | XLEN/2 | Original process of the running task |
| handler_active | input | 1 | An exception or interrupt handler is active |
| queue_new | input | 1 | A new instruction queue begins |
| queue_drained | input | 1 | Queued instructions have written back |
| ret_ip | input | XLEN | IP resumed once all handlers return |
| ret_pr | input | XLEN | PR resumed once all handlers return |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| exc | output | 1 | One-cycle refusal pulse |
| exc_cause | output | 3 | Cause code of the last refusal |
| irq_reenable | output | 1 | Interrupt acceptance re-enabled |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data, one cycle after read |
| ctx_addr | output | SLOT_W | Context slot address |
| ctx_we | output | 1 | Context write strobe |
| ctx_wdata | output | XLEN | Context write data |
| ctx_rdata | input | XLEN | Context read data for ctx_addr, same cycle |

## Verification
The main function is exercised with each of the four operations from a fixed descriptor image in which entries differ by identifier, validity and running state. Success cases are checked word by word, so a save written to the wrong entry, a swapped word offset or a missing read-modify-write is exposed. Refusal patterns cover a wrong issuer, a wrong identifier, an invalid target and a running target. Each refusal is checked for its cause code and for an untouched table, which separates the individual guards and their priority. Further patterns cover a handler exit from an invalid current entry, an all-ones segment argument, a repeated command within one queue, and a command held back by an undrained queue while a second request arrives.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    OP_CALL   = 2'd0,
    OP_RET    = 2'd1,
    OP_SWITCH = 2'd2,
    OP_SWEXIT = 2'd3
  } tss_op_e;

  typedef enum logic [2:0] {
    C_NONE    = 3'd0,
    C_PRIV    = 3'd1,
    C_DOUBLE  = 3'd2,
    C_IDMISM  = 3'd3,
    C_INVALID = 3'd4,
    C_RUNNING = 3'd5
  } tss_cause_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAITQ, S_RD0, S_RD1, S_EVAL, S_SAVE, S_LOAD, S_FIX
  } tss_state_e;

  // descriptor word offsets
  localparam int unsigned W_ID   = 0;
  localparam int unsigned W_PR   = 2;
  localparam int unsigned W_CALL = 3;
  localparam int unsigned W_SEG  = 4;
  localparam int unsigned W_REGS = 5;
endpackage

// File: rtl/tss_addr_gen.sv
module tss_addr_gen #(
  parameter int AW     = 8,
  parameter int IDX_W  = 2,
  parameter int NREG   = 4,
  parameter int BASE   = 16,
  parameter int WOFF_W = 4
) (
  input  logic [IDX_W-1:0]  entry,
  input  logic [WOFF_W-1:0] woff,
  output logic [AW-1:0]     addr
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] ENT_A  = AW'(NREG + 5);

  assign addr = BASE_A + AW'(entry) * ENT_A + AW'(woff);
endmodule

// File: rtl/tss_slot_map.sv
module tss_slot_map #(
  parameter int NREG   = 4,
  parameter int SLOT_W = 3,
  parameter int WOFF_W = 4
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        op,
  output logic [WOFF_W-1:0] woff,
  output logic              save_en,
  output logic              load_en
);
  import tss_pkg::*;
  localparam int NSLOT = NREG + 2;

  logic in_rng, is_ipsp, is_seg, is_pr;

  always_comb begin
    in_rng  = slot < SLOT_W'(NSLOT);
    is_ipsp = slot < SLOT_W'(2);
    is_seg  = slot == SLOT_W'(NREG);
    is_pr   = slot == SLOT_W'(NREG + 1);
    if (is_seg)      woff = WOFF_W'(W_SEG);
    else if (is_pr)  woff = WOFF_W'(W_PR);
    else             woff = WOFF_W'(W_REGS) + WOFF_W'(slot);
    case (tss_op_e'(op))
      OP_CALL: begin
        save_en = is_ipsp | is_seg | is_pr;
        load_en = is_seg | is_pr;
      end
      OP_RET: begin
        save_en = 1'b0;
        load_en = is_ipsp | is_seg | is_pr;
      end
      default: begin
        save_en = in_rng;
        load_en = in_rng;
      end
    endcase
  end
endmodule

// File: rtl/tss_switch_seq.sv
module tss_switch_seq #(
  parameter int XLEN   = 16,
  parameter int NREG   = 4,
  parameter int AW     = 8,
  parameter int IDX_W  = 2,
  parameter int BASE   = 16,
  parameter int FLAG_W = 2,
  localparam int HALF   = XLEN / 2,
  localparam int SLOT_W = $clog2(NREG + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [HALF-1:0]   cmd_id,
  input  logic [HALF-1:0]   cmd_seg,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [HALF-1:0]   issuer_pid,
  input  logic [HALF-1:0]   orig_pid,
  input  logic              handler_active,
  input  logic              queue_new,
  input  logic              queue_drained,
  input  logic [XLEN-1:0]   ret_ip,
  input  logic [XLEN-1:0]   ret_pr,
  output logic              busy,
  output logic              done,
  output logic              exc,
  output logic [2:0]        exc_cause,
  output logic              irq_reenable,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [SLOT_W-1:0] ctx_addr,
  output logic              ctx_we,
  output logic [XLEN-1:0]   ctx_wdata,
  input  logic [XLEN-1:0]   ctx_rdata
);
  import tss_pkg::*;

  localparam int NSLOT  = NREG + 2;
  localparam int WOFF_W = $clog2(NREG + 5);
  localparam int VAL_B  = HALF - FLAG_W;
  localparam int RUN_B  = HALF - FLAG_W + 1;
  localparam logic [XLEN-1:0] RUN_M = XLEN'(1) << RUN_B;
  localparam logic [SLOT_W-1:0] SL_LAST = SLOT_W'(NSLOT - 1);
  localparam logic [SLOT_W-1:0] SL_END  = SLOT_W'(NSLOT);
  localparam logic [SLOT_W-1:0] SL_PR   = SLOT_W'(NREG + 1);
  localparam logic [SLOT_W-1:0] SL_ARG  = SLOT_W'(NREG + 2);

  tss_state_e st_q, st_n;
  tss_op_e    op_q;
  logic [IDX_W-1:0] idx_q, cur_q, ent;
  logic [HALF-1:0]  id_q, seg_q, orig_q;
  logic [XLEN-1:0]  tgt_w0_q, cur_w0_q;
  logic [SLOT_W-1:0] cnt_q, cnt_n;
  logic [2:0] fx_q, fx_n, cause_n;
  logic seen_q, seen_n, done_n, exc_n, irq_n, accept, priv_bad;
  logic [WOFF_W-1:0] woff, woff0, woff1;
  logic sv0, ld0, sv1, ld1, is_sw;

  tss_slot_map #(.NREG(NREG), .SLOT_W(SLOT_W), .WOFF_W(WOFF_W)) u_map0 (
    .slot(cnt_q), .op(op_q), .woff(woff0), .save_en(sv0), .load_en(ld0));
  tss_slot_map #(.NREG(NREG), .SLOT_W(SLOT_W), .WOFF_W(WOFF_W)) u_map1 (
    .slot(cnt_q - SLOT_W'(1)), .op(op_q), .woff(woff1), .save_en(sv1), .load_en(ld1));
  tss_addr_gen #(.AW(AW), .IDX_W(IDX_W), .NREG(NREG), .BASE(BASE), .WOFF_W(WOFF_W)) u_agen (
    .entry(ent), .woff(woff), .addr(mem_addr));

  assign accept = cmd_valid && (st_q == S_IDLE);
  assign busy   = (st_q != S_IDLE);
  assign is_sw  = (op_q == OP_SWITCH) || (op_q == OP_SWEXIT);

  always_comb begin
    case (tss_op_e'(cmd_op))
      OP_RET:    priv_bad = (issuer_pid == orig_pid);
      OP_SWEXIT: priv_bad = !handler_active;
      default:   priv_bad = (issuer_pid != orig_pid);
    endcase
  end

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; fx_n = fx_q;
    seen_n = queue_new ? 1'b0 : seen_q;
    done_n = 1'b0; exc_n = 1'b0; irq_n = 1'b0; cause_n = exc_cause;
    mem_re = 1'b0; mem_we = 1'b0; mem_wdata = '0;
    ctx_we = 1'b0; ctx_wdata = '0; ctx_addr = cnt_q;
    ent = idx_q; woff = WOFF_W'(W_ID);
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin
        seen_n = 1'b1;
        if (seen_q && !queue_new) begin exc_n = 1'b1; cause_n = C_DOUBLE; end
        else if (priv_bad)        begin exc_n = 1'b1; cause_n = C_PRIV; end
        else st_n = S_WAITQ;
      end
      S_WAITQ: if (queue_drained) st_n = S_RD0;
      S_RD0: begin mem_re = 1'b1; st_n = S_RD1; end
      S_RD1: begin mem_re = 1'b1; ent = cur_q; st_n = S_EVAL; end
      S_EVAL: begin
        cnt_n = '0;
        if ((op_q == OP_CALL || op_q == OP_SWITCH) && tgt_w0_q[XLEN-1:HALF] != id_q) begin
          exc_n = 1'b1; cause_n = C_IDMISM; st_n = S_IDLE;
        end else if (op_q != OP_RET && !tgt_w0_q[VAL_B]) begin
          exc_n = 1'b1; cause_n = C_INVALID; st_n = S_IDLE;
        end else if (is_sw && tgt_w0_q[RUN_B]) begin
          exc_n = 1'b1; cause_n = C_RUNNING; st_n = S_IDLE;
        end else if (op_q == OP_RET || (op_q == OP_SWEXIT && !mem_rdata[VAL_B]))
          st_n = S_LOAD;
        else
          st_n = S_SAVE;
      end
      S_SAVE: begin
        ent = cur_q; woff = woff0; mem_we = sv0;
        if (op_q == OP_SWEXIT && cnt_q == '0)        mem_wdata = ret_ip;
        else if (op_q == OP_SWEXIT && cnt_q == SL_PR) mem_wdata = ret_pr;
        else                                          mem_wdata = ctx_rdata;
        cnt_n = cnt_q + SLOT_W'(1);
        if (cnt_q == SL_LAST) begin cnt_n = '0; st_n = S_LOAD; end
      end
      S_LOAD: begin
        ent = (op_q == OP_RET) ? cur_q : idx_q; woff = woff0;
        mem_re = ld0;
        if (cnt_q != '0 && ld1) begin
          ctx_we = 1'b1; ctx_addr = cnt_q - SLOT_W'(1); ctx_wdata = mem_rdata;
        end
        cnt_n = cnt_q + SLOT_W'(1);
        if (cnt_q == SL_END) begin fx_n = '0; st_n = S_FIX; end
      end
      S_FIX: begin
        fx_n = fx_q + 3'd1;
        if (is_sw) begin
          if (fx_q == 3'd0) begin
            ent = cur_q; mem_wdata = cur_w0_q & ~RUN_M;
            mem_we = (op_q == OP_SWITCH) || cur_w0_q[VAL_B];
          end else begin
            mem_we = 1'b1; mem_wdata = tgt_w0_q | RUN_M;
            st_n = S_IDLE; done_n = 1'b1; irq_n = (op_q == OP_SWEXIT);
          end
        end else begin
          woff = WOFF_W'(W_CALL); ent = cur_q;
          case (fx_q)
            3'd0: mem_re = 1'b1;
            3'd1: begin
              mem_we = 1'b1;
              mem_wdata = {mem_rdata[XLEN-1:HALF], (op_q == OP_RET) ? orig_q : HALF'(idx_q)};
              if (op_q == OP_RET) begin st_n = S_IDLE; done_n = 1'b1; end
            end
            3'd2: begin mem_re = 1'b1; ent = idx_q; end
            3'd3: begin
              ctx_we = 1'b1; ctx_addr = '0;
              ctx_wdata = {mem_rdata[XLEN-1:HALF], {HALF{1'b0}}};
            end
            default: begin
              ctx_addr = SL_ARG; ctx_we = (seg_q != {HALF{1'b1}});
              ctx_wdata = XLEN'(seg_q);
              st_n = S_IDLE; done_n = 1'b1;
            end
          endcase
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; fx_q <= '0; seen_q <= 1'b0;
      done <= 1'b0; exc <= 1'b0; exc_cause <= '0; irq_reenable <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; fx_q <= fx_n; seen_q <= seen_n;
      done <= done_n; exc <= exc_n; exc_cause <= cause_n; irq_reenable <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_CALL; idx_q <= '0; cur_q <= '0; id_q <= '0; seg_q <= '0; orig_q <= '0;
      tgt_w0_q <= '0; cur_w0_q <= '0;
    end else begin
      if (accept) begin
        op_q <= tss_op_e'(cmd_op); idx_q <= cmd_idx; cur_q <= cur_idx;
        id_q <= cmd_id; seg_q <= cmd_seg; orig_q <= orig_pid;
      end
      if (st_q == S_RD1)  tgt_w0_q <= mem_rdata;
      if (st_q == S_EVAL) cur_w0_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/tss_seq_chk.sv
module tss_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic queue_drained,
  input logic busy,
  input logic done,
  input logic exc,
  input logic [2:0] exc_cause,
  input logic irq_reenable,
  input logic mem_re,
  input logic mem_we,
  input logic ctx_we
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed_q <= 1'b0;
    else if (queue_drained)     armed_q <= 1'b0;
    else if (cmd_valid && !busy) armed_q <= 1'b1;
  end

  assert_one_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  assert_no_early_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || ctx_we) |-> !armed_q);
  assert_single_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc));
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || exc) |=> !(done || exc) || $past(cmd_valid));
  assert_idle_at_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || exc) |-> !busy);
  assert_cause_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (exc_cause != 3'd0));
  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_reenable |-> done);
endmodule

bind tss_switch_seq tss_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .queue_drained(queue_drained),
  .busy(busy), .done(done), .exc(exc), .exc_cause(exc_cause),
  .irq_reenable(irq_reenable), .mem_re(mem_re), .mem_we(mem_we), .ctx_we(ctx_we));

// File: tb/sim_tss_switch_seq.sv
module sim_tss_switch_seq;
  localparam int XLEN = 16, NREG = 4, AW = 8, IDX_W = 2, BASE = 16, ENTW = NREG + 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, handler_active = 0, queue_new = 0, queue_drained = 1;
  logic [1:0] cmd_op = 0, cmd_idx = 0, cur_idx = 0;
  logic [7:0] cmd_id = 0, cmd_seg = 8'hFF, issuer_pid = 0, orig_pid = 0;
  logic [15:0] ret_ip = 16'h7777, ret_pr = 16'h8888;
  logic busy, done, exc, irq_reenable, mem_re, mem_we, ctx_we;
  logic [2:0] exc_cause, ctx_addr;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, ctx_wdata, ctx_rdata;
  logic [15:0] mem_rdata;
  logic [15:0] mem [256];
  logic [15:0] ctx [8];

  int checks = 0, failures = 0, cyc = 0, wr_seen = 0;
  logic r_done, r_exc, r_irq;
  logic [2:0] r_cause;

  always #10 clk = ~clk;

  tss_switch_seq u0 (.*);

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (ctx_we) ctx[ctx_addr] <= ctx_wdata;
    if (mem_we || ctx_we) wr_seen <= wr_seen + 1;
  end
  assign ctx_rdata = ctx[ctx_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL R13 watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int ea(int e, int w);
    return BASE + e * ENTW + w;
  endfunction

  function automatic logic [15:0] init_word(int e, int w);
    logic [7:0] fl [4] = '{8'hC0, 8'h40, 8'h00, 8'hC0};
    case (w)
      0: return {8'hA0 + 8'(e), fl[e]};
      1: return 16'h1000 + 16'(e);
      2: return 16'h2000 + 16'(e);
      3: return {8'h30 + 8'(e), 8'(e)};
      4: return 16'h4000 + 16'(e);
      default: return 16'h5000 + 16'(e * 16 + w - 5);
    endcase
  endfunction

  task automatic init_all();
    for (int a = 0; a < 256; a++) mem[a] = 16'h0;
    for (int e = 0; e < 4; e++)
      for (int w = 0; w < ENTW; w++) mem[ea(e, w)] = init_word(e, w);
    for (int s = 0; s < 8; s++) ctx[s] = 16'hC000 + 16'(s);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic new_queue();
    @(negedge clk) queue_new = 1;
    @(negedge clk) queue_new = 0;
  endtask

  task automatic run(input logic [1:0] op, input logic [1:0] idx, input logic [7:0] id,
                     input logic [7:0] seg, input logic [7:0] iss, input logic [7:0] orig,
                     input logic hnd, input logic [1:0] cur);
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_id = id; cmd_seg = seg; issuer_pid = iss;
    orig_pid = orig; handler_active = hnd; cur_idx = cur; cmd_valid = 1;
    @(negedge clk) cmd_valid = 0;
    r_irq = 0;
    for (int t = 0; t < 300; t++) begin
      if (irq_reenable) r_irq = 1;
      if (done || exc) break;
      @(negedge clk);
    end
    r_done = done; r_exc = exc; r_cause = exc_cause;
  endtask

  function automatic int table_diffs();
    int d = 0;
    for (int e = 0; e < 4; e++)
      for (int w = 0; w < ENTW; w++) if (mem[ea(e, w)] !== init_word(e, w)) d++;
    return d;
  endfunction

  // {op, idx, id, seg, issuer, orig, handler, cur, cause}
  localparam logic [41:0] VEC [12] = '{
    {2'd0, 2'd1, 8'hA1, 8'h07, 8'h00, 8'h00, 1'b0, 2'd0, 3'd0},
    {2'd0, 2'd1, 8'hA5, 8'h07, 8'h00, 8'h00, 1'b0, 2'd0, 3'd3},
    {2'd0, 2'd2, 8'hA2, 8'h07, 8'h00, 8'h00, 1'b0, 2'd0, 3'd4},
    {2'd0, 2'd1, 8'hA1, 8'h07, 8'h01, 8'h00, 1'b0, 2'd0, 3'd1},
    {2'd1, 2'd0, 8'h00, 8'hFF, 8'h01, 8'h00, 1'b0, 2'd0, 3'd0},
    {2'd1, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0, 3'd1},
    {2'd2, 2'd1, 8'hA1, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0, 3'd0},
    {2'd2, 2'd3, 8'hA3, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0, 3'd5},
    {2'd3, 2'd1, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b1, 2'd0, 3'd0},
    {2'd3, 2'd1, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0, 3'd1},
    {2'd3, 2'd2, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b1, 2'd0, 3'd4},
    {2'd2, 2'd1, 8'hA1, 8'hFF, 8'h02, 8'h00, 1'b0, 2'd0, 3'd1}
  };

  initial begin
    init_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset busy", busy, 0);
    chk("R13 reset done/exc", {done, exc, irq_reenable}, 0);
    chk("R12 reset strobes", {mem_we, ctx_we}, 0);

    // table: cause codes and untouched table on refusals (R2 R3)
    foreach (VEC[i]) begin
      logic [41:0] v = VEC[i];
      init_all();
      new_queue();
      run(v[41:40], v[39:38], v[37:30], v[29:22], v[21:14], v[13:6], v[5], v[4:3]);
      if (v[2:0] == 3'd0) chk("R13 success ends in done", {r_done, r_exc}, 2'b10);
      else begin
        chk(v[2:0] == 3'd1 ? "R2 refusal cause" : "R3 refusal cause", {r_exc, r_cause}, {1'b1, v[2:0]});
        chk("R3 table unchanged after refusal", table_diffs(), 0);
      end
    end

    // R4 R5 R6 R1: call
    init_all(); new_queue();
    run(2'd0, 2'd1, 8'hA1, 8'h07, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R4 IP saved", mem[ea(0,5)], 16'hC000);
    chk("R4 SP saved", mem[ea(0,6)], 16'hC001);
    chk("R4 seg saved", mem[ea(0,4)], 16'hC004);
    chk("R4 PR saved", mem[ea(0,2)], 16'hC005);
    chk("R5 current process field", mem[ea(0,3)], 16'h3001);
    chk("R5 callee seg loaded", ctx[4], 16'h4001);
    chk("R5 callee PR loaded", ctx[5], 16'h2001);
    chk("R5 IP at callable seg", ctx[0], 16'h3100);
    chk("R5 GPR untouched", ctx[2], 16'hC002);
    chk("R6 segment passed", ctx[6], 16'h0007);
    chk("R1 other entries untouched", mem[ea(1,3)], 16'h3101);
    init_all(); new_queue();
    run(2'd0, 2'd1, 8'hA1, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R6 all-ones passes nothing", ctx[6], 16'hC006);

    // R7 return
    init_all(); new_queue();
    run(2'd1, 2'd0, 8'h00, 8'hFF, 8'h01, 8'h05, 1'b0, 2'd0);
    chk("R7 IP restored", ctx[0], 16'h5000);
    chk("R7 SP restored", ctx[1], 16'h5001);
    chk("R7 seg restored", ctx[4], 16'h4000);
    chk("R7 PR restored", ctx[5], 16'h2000);
    chk("R7 GPR untouched", ctx[2], 16'hC002);
    chk("R7 process field restored", mem[ea(0,3)], 16'h3005);

    // R8 switch
    init_all(); new_queue();
    run(2'd2, 2'd1, 8'hA1, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R8 GPR saved", mem[ea(0,8)], 16'hC003);
    chk("R8 PR saved", mem[ea(0,2)], 16'hC005);
    chk("R8 regs loaded", {ctx[0], ctx[3]}, {16'h5010, 16'h5013});
    chk("R8 seg/PR loaded", {ctx[4], ctx[5]}, {16'h4001, 16'h2001});
    chk("R8 current flags", mem[ea(0,0)], 16'hA040);
    chk("R8 target flags", mem[ea(1,0)], 16'hA1C0);

    // R9 handler-exit
    init_all(); new_queue();
    run(2'd3, 2'd1, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b1, 2'd0);
    chk("R9 return IP saved", mem[ea(0,5)], 16'h7777);
    chk("R9 return PR saved", mem[ea(0,2)], 16'h8888);
    chk("R9 SP saved live", mem[ea(0,6)], 16'hC001);
    chk("R9 irq reenabled", {r_irq, r_done}, 2'b11);
    chk("R9 target loaded", ctx[0], 16'h5010);

    // R10 handler-exit from invalid entry
    init_all(); new_queue();
    run(2'd3, 2'd1, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b1, 2'd2);
    chk("R10 no save", {mem[ea(2,5)], mem[ea(2,2)]}, {16'h5020, 16'h2002});
    chk("R10 no flag write", mem[ea(2,0)], 16'hA200);
    chk("R10 target loaded", {ctx[0], mem[ea(1,0)]}, {16'h5010, 16'hA1C0});

    // R11 double command
    init_all(); new_queue();
    run(2'd0, 2'd1, 8'hA1, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0);
    init_all();
    run(2'd0, 2'd1, 8'hA1, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R11 second in queue refused", {r_exc, r_cause}, {1'b1, 3'd2});
    chk("R11 table unchanged", table_diffs(), 0);
    new_queue();
    run(2'd0, 2'd1, 8'hA1, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R11 new queue accepts", {r_done, r_exc}, 2'b10);

    // R12 R13 drain wait with ignored request while busy
    init_all(); new_queue();
    queue_drained = 0;
    @(negedge clk);
    cmd_op = 2'd2; cmd_idx = 2'd1; cmd_id = 8'hA1; issuer_pid = 0; orig_pid = 0; cur_idx = 0;
    cmd_valid = 1;
    @(negedge clk) cmd_valid = 0;
    wr_seen = 0;
    repeat (3) @(negedge clk);
    cmd_op = 2'd1; cmd_valid = 1;
    @(negedge clk) cmd_valid = 0;
    repeat (5) @(negedge clk);
    chk("R12 no writes before drain", wr_seen, 0);
    chk("R13 busy while waiting", busy, 1);
    queue_drained = 1;
    r_exc = 0; r_done = 0;
    for (int t = 0; t < 300; t++) begin
      if (exc) r_exc = 1;
      if (done) begin r_done = 1; break; end
      @(negedge clk);
    end
    chk("R13 request while busy ignored", {r_done, r_exc}, 2'b10);
    chk("R12 switch completes after drain", ctx[0], 16'h5010);
    @(negedge clk);
    chk("R13 done is one pulse", {done, busy}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule